// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block sits between a simple host port and a two-bank synchronous DRAM. On the host side it accepts one access at a time through a valid/ready handshake. Each access carries a word address and a direction flag. On the memory side it drives the four command strobes, clock enable, a bank-select bit and an 11-bit multiplexed address bus. Each accepted access becomes an activate followed by a read or write column command, and that column command always closes the row through the auto-precharge flag.

After reset the controller raises clock enable and waits a programmable settling time. It then precharges both banks, runs two refreshes and loads the mode register with burst length one, sequential order and the configured CAS latency. Only after that does it take host traffic. A free-running interval timer spreads the required 2048 refreshes over a 32 ms window, or over a 16 ms window when the half-window parameter is set. A due refresh is served ahead of new host requests. Two enable strobes tell an external data path when write data must be driven and when read data arrives. The gaps between commands (activate to column, row cycle, precharge recovery, refresh recovery, mode-load recovery) are clock-count parameters.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is low the controller deselects the device (CS, RAS, CAS, WE all 1), holds CKE low and holds reqReady low. In the first cycle after reset the strobes show NOP.
- R2: CKE goes high in the first cycle after reset and is high at least one cycle before every command. The first command comes no sooner than T_INIT cycles after reset. The start-up order is precharge-all (A10=1), refresh, refresh, then mode-register load with A[6:4]=CAS_LAT and all other address bits 0. The gaps in this sequence are at least T_RP, T_RFC and T_RFC. reqReady stays low until the mode load has been issued, and the next command follows it by at least T_MRD.
- R3: Commands are encoded on {CS,RAS,CAS,WE} as activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000 and NOP 0111. A write request produces a write command and a read request produces a read. After start-up no precharge or mode load is issued.
- R4: The request address splits as bank = reqAddr[19], row = reqAddr[18:8] and column = reqAddr[7:0]. An activate drives the bank and the row on A10..A0. The column command drives the same bank, puts the column on A7..A0, A9..A8 = 0 and A10 = 1 (auto-precharge).
- R5: The column command follows its activate by exactly T_RCD cycles.
- R6: Two activates are at least T_RC cycles apart. A column command is followed by the next activate or refresh no sooner than T_RP cycles later.
- R7: A refresh is followed by any other command no sooner than T_RFC cycles later.
- R8: A refresh falls due every REF_GAP = CLK_KHZ*W/2048 cycles, where W = 32 (HALF_WINDOW=0) or 16 (HALF_WINDOW=1). Over any long stretch, the refresh count matches the elapsed cycles divided by REF_GAP, to within one.
- R9: A due refresh wins over a waiting host request. Even under continuous host load, two consecutive refreshes are never more than REF_GAP + T_RCD + max(T_RC-T_RCD, T_RP) + 1 cycles apart.
- R10: A request is taken in a cycle where reqValid and reqReady are both high. Its activate appears on the pins in the next cycle. reqReady stays low while an accepted access has not yet issued its column command.
- R11: wrDataEn is high exactly in the cycles in which a write command is on the pins. rdDataValid is high exactly CAS_LAT cycles after a read command is on the pins.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host has an access to offer |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 20 | Word address: bank, row, column |
| reqReady | output | 1 | Controller takes the offered access this cycle |
| sdCke | output | 1 | Memory clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 1 | Bank select |
| sdAddr | output | 11 | Multiplexed row / column / mode address |
| wrDataEn | output | 1 | Write data must be driven this cycle |
| rdDataValid | output | 1 | Read data is on the bus this cycle |

## Verification
The activate for an accepted request is due one cycle after the acceptance cycle. The column command follows T_RCD cycles later, wrDataEn is high in the write command's own cycle, and rdDataValid comes CAS_LAT cycles after the read command. The bench samples every pin at the falling edge and numbers each cycle from reset release. It compares the cycle number of each command against these offsets exactly, and against the minimum gaps T_RC, T_RP, T_RFC and T_MRD as lower bounds. Refresh timing is judged over a long window: the count of refreshes against the elapsed cycles divided by REF_GAP, and the longest spacing under load against the R9 bound. A second idle instance with the half window should show twice the rate.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {CS, RAS, CAS, WE}, all active low
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdCmd_e;

  // control -> datapath strobes, one set per cycle
  typedef struct packed {
    sdCmd_e cmd;      // command to place on the pins next cycle
    logic   takeReq;  // latch the host address
    logic   apFlag;   // value for the auto-precharge / all-banks bit
  } seqStrobe_t;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int T_INIT  = 20000,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_RC    = 7,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int REF_GAP = 1562
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       ckeOn,
  output seqStrobe_t strobe
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Gap after a column command: covers the rest of the row cycle and the precharge.
  localparam int POST_RW = maxOf(T_RC - T_RCD, T_RP);
  localparam int BIGGEST = maxOf(maxOf(T_INIT, POST_RW),
                                 maxOf(maxOf(T_RFC, T_MRD), maxOf(T_RP, T_RCD)));
  localparam int GW = $clog2(BIGGEST + 1);
  localparam int RW = $clog2(REF_GAP + 1);

  typedef enum logic [2:0] {
    S_BOOT, S_PRE_ALL, S_REF_A, S_REF_B, S_MODE, S_IDLE, S_COL
  } seqState_e;

  seqState_e state, stateNxt;
  logic [GW-1:0] gapCnt, gapLoadVal;
  logic          gapLoad;
  logic          gapDone;
  logic [RW-1:0] refCnt;
  logic          refPend, refTake;
  logic          wrFlag;

  assign gapDone = (gapCnt == '0);

  // Sequencer decision for this cycle
  always_comb begin
    stateNxt       = state;
    strobe.cmd     = CMD_NOP;
    strobe.takeReq = 1'b0;
    strobe.apFlag  = 1'b0;
    gapLoad        = 1'b0;
    gapLoadVal     = '0;
    refTake        = 1'b0;
    reqReady       = 1'b0;
    case (state)
      S_BOOT: begin
        if (gapDone) stateNxt = S_PRE_ALL;
      end
      S_PRE_ALL: begin
        strobe.cmd    = CMD_PRE;
        strobe.apFlag = 1'b1;
        gapLoad       = 1'b1;
        gapLoadVal    = GW'(T_RP - 1);
        stateNxt      = S_REF_A;
      end
      S_REF_A: begin
        if (gapDone) begin
          strobe.cmd = CMD_REF;
          gapLoad    = 1'b1;
          gapLoadVal = GW'(T_RFC - 1);
          stateNxt   = S_REF_B;
        end
      end
      S_REF_B: begin
        if (gapDone) begin
          strobe.cmd = CMD_REF;
          gapLoad    = 1'b1;
          gapLoadVal = GW'(T_RFC - 1);
          stateNxt   = S_MODE;
        end
      end
      S_MODE: begin
        if (gapDone) begin
          strobe.cmd = CMD_MRS;
          gapLoad    = 1'b1;
          gapLoadVal = GW'(T_MRD - 1);
          stateNxt   = S_IDLE;
        end
      end
      S_IDLE: begin
        reqReady = gapDone && !refPend;
        if (gapDone && refPend) begin
          strobe.cmd = CMD_REF;
          refTake    = 1'b1;
          gapLoad    = 1'b1;
          gapLoadVal = GW'(T_RFC - 1);
        end else if (gapDone && reqValid) begin
          strobe.cmd     = CMD_ACT;
          strobe.takeReq = 1'b1;
          gapLoad        = 1'b1;
          gapLoadVal     = GW'(T_RCD - 1);
          stateNxt       = S_COL;
        end
      end
      S_COL: begin
        if (gapDone) begin
          strobe.cmd    = wrFlag ? CMD_WR : CMD_RD;
          strobe.apFlag = 1'b1;
          gapLoad       = 1'b1;
          gapLoadVal    = GW'(POST_RW - 1);
          stateNxt      = S_IDLE;
        end
      end
      default: stateNxt = S_BOOT;
    endcase
  end

  // The boot state is left one cycle before the precharge is decided, so the
  // counter starts one short of T_INIT.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_BOOT;
      gapCnt <= GW'(T_INIT - 1);
      wrFlag <= 1'b0;
      ckeOn  <= 1'b0;
    end else begin
      state <= stateNxt;
      ckeOn <= 1'b1;
      if (gapLoad)       gapCnt <= gapLoadVal;
      else if (!gapDone) gapCnt <= gapCnt - 1'b1;
      if (strobe.takeReq) wrFlag <= reqWrite;
    end
  end

  // Refresh interval timer, free running from reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt  <= RW'(REF_GAP - 1);
      refPend <= 1'b0;
    end else begin
      if (refCnt == '0) refCnt <= RW'(REF_GAP - 1);
      else              refCnt <= refCnt - 1'b1;
      if (refCnt == '0)  refPend <= 1'b1;
      else if (refTake)  refPend <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_pin_path.sv
module sdram_pin_path
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 3,
  localparam int ADDR_W = 1 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic              wrDataEn,
  output logic              rdDataValid
);

  // burst length 1, sequential order, CAS latency in bits 6:4
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  sdCmd_e             cmdQ;
  logic               bankQ;
  logic [COL_W-1:0]   colQ;
  logic [ROW_W-1:0]   colWord, apWord;
  logic [CAS_LAT-1:0] rdPipe;

  always_comb begin
    apWord         = '0;
    apWord[AP_BIT] = strobe.apFlag;
    colWord        = apWord;
    colWord[COL_W-1:0] = colQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_DESEL;
      sdBa     <= 1'b0;
      sdAddr   <= '0;
      bankQ    <= 1'b0;
      colQ     <= '0;
      wrDataEn <= 1'b0;
      rdPipe   <= '0;
    end else begin
      cmdQ     <= strobe.cmd;
      wrDataEn <= (strobe.cmd == CMD_WR);
      rdPipe   <= CAS_LAT'({rdPipe, (cmdQ == CMD_RD)});
      if (strobe.takeReq) begin
        bankQ <= reqAddr[ADDR_W-1];
        colQ  <= reqAddr[COL_W-1:0];
      end
      case (strobe.cmd)
        CMD_ACT: begin
          sdBa   <= reqAddr[ADDR_W-1];
          sdAddr <= reqAddr[ADDR_W-2 -: ROW_W];
        end
        CMD_RD, CMD_WR: begin
          sdBa   <= bankQ;
          sdAddr <= colWord;
        end
        CMD_PRE: begin
          sdBa   <= 1'b0;
          sdAddr <= apWord;
        end
        CMD_MRS: begin
          sdBa   <= 1'b0;
          sdAddr <= MODE_WORD;
        end
        default: ;
      endcase
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;
  assign rdDataValid = rdPipe[CAS_LAT-1];

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 8,
  parameter int AP_BIT      = 10,
  parameter int CAS_LAT     = 3,
  parameter int CLK_KHZ     = 100000,
  parameter bit HALF_WINDOW = 1'b0,
  parameter int REF_ROWS    = 2048,
  parameter int T_INIT      = 20000,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RC        = 7,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2,
  localparam int ADDR_W     = 1 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic              wrDataEn,
  output logic              rdDataValid
);

  localparam int WINDOW_MS = HALF_WINDOW ? 16 : 32;
  localparam int REF_GAP   = (CLK_KHZ * WINDOW_MS) / REF_ROWS;

  seqStrobe_t strobe;

  sdram_seq_ctrl #(
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .REF_GAP(REF_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ckeOn(sdCke), .strobe(strobe)
  );

  sdram_pin_path #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .CAS_LAT(CAS_LAT)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .wrDataEn(wrDataEn), .rdDataValid(rdDataValid)
  );

endmodule

// File: rtl/sdram_ctrl_checker.sv
module sdram_ctrl_checker #(
  parameter int T_RCD   = 2,
  parameter int T_RC    = 7,
  parameter int T_RFC   = 7,
  parameter int CAS_LAT = 3
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic sdCke,
  input logic sdCsN,
  input logic sdRasN,
  input logic sdCasN,
  input logic sdWeN,
  input logic apBit,
  input logic rdDataValid
);

  logic [3:0]  cmd;
  logic        isCmd, isCol, isRd;
  logic [15:0] sinceAct, sinceRef;

  assign cmd   = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isCmd = (cmd != 4'b0111) && (cmd != 4'b1111);
  assign isCol = (cmd == 4'b0100) || (cmd == 4'b0101);
  assign isRd  = (cmd == 4'b0101);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= 16'hffff;
      sinceRef <= 16'hffff;
    end else begin
      if (cmd == 4'b0011)         sinceAct <= 16'd1;
      else if (sinceAct != 16'hffff) sinceAct <= sinceAct + 16'd1;
      if (cmd == 4'b0001)         sinceRef <= 16'd1;
      else if (sinceRef != 16'hffff) sinceRef <= sinceRef + 16'd1;
    end
  end

  a_r2_cke_ahead: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |-> $past(sdCke));

  a_r4_auto_precharge: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> apBit);

  a_r5_rcd_exact: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> (sinceAct == 16'(T_RCD)));

  a_r6_row_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0011) |-> (sinceAct >= 16'(T_RC)));

  a_r7_refresh_recovery: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && cmd != 4'b0001) |-> (sinceRef >= 16'(T_RFC)));

  a_r10_act_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (cmd == 4'b0011));

  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdDataValid |-> $past(isRd, CAS_LAT));

endmodule

bind sdram_cmd_ctrl sdram_ctrl_checker #(
  .T_RCD(T_RCD), .T_RC(T_RC), .T_RFC(T_RFC), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .apBit(sdAddr[AP_BIT]), .rdDataValid(rdDataValid)
);

// File: tb/sim_sdram_cmd_ctrl.sv
module sim_sdram_cmd_ctrl;

  localparam int T_INIT  = 20;
  localparam int T_RCD   = 2;
  localparam int T_RP    = 3;
  localparam int T_RC    = 7;
  localparam int T_RFC   = 6;
  localparam int T_MRD   = 2;
  localparam int CAS_LAT = 3;
  localparam int CLK_KHZ = 6400;
  localparam int GAP_FULL = CLK_KHZ * 32 / 2048;   // 100
  localparam int GAP_HALF = CLK_KHZ * 16 / 2048;   // 50
  localparam int POST_RW = (T_RC - T_RCD > T_RP) ? T_RC - T_RCD : T_RP;
  localparam int SLACK   = T_RCD + POST_RW + 1;
  localparam int RUN     = 4000;
  localparam int WD      = 20000;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, reqValid, reqWrite;
  logic [19:0] reqAddr;
  logic        reqReady, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdBa, wrDataEn, rdDataValid;
  logic [10:0] sdAddr;
  logic        r1, k1, cs1, ras1, cas1, we1, ba1, wr1, rv1;
  logic [10:0] a1;

  sdram_cmd_ctrl #(.CAS_LAT(CAS_LAT), .CLK_KHZ(CLK_KHZ), .HALF_WINDOW(1'b0),
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RFC(T_RFC),
    .T_MRD(T_MRD)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .wrDataEn(wrDataEn), .rdDataValid(rdDataValid));

  sdram_cmd_ctrl #(.CAS_LAT(CAS_LAT), .CLK_KHZ(CLK_KHZ), .HALF_WINDOW(1'b1),
    .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RFC(T_RFC),
    .T_MRD(T_MRD)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .reqWrite(1'b0), .reqAddr(20'd0),
    .reqReady(r1), .sdCke(k1), .sdCsN(cs1), .sdRasN(ras1), .sdCasN(cas1),
    .sdWeN(we1), .sdBa(ba1), .sdAddr(a1), .wrDataEn(wr1), .rdDataValid(rv1));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected-value helpers
  function automatic logic [10:0] colWord(input logic [19:0] a);
    return {1'b1, 2'b00, a[7:0]};
  endfunction
  function automatic int refExpect(input int len, input int gap);
    return len / gap;
  endfunction

  // bench state
  int lastAct = -1000, lastRw = -1000, lastRef = -1000, lastRd = -1000, lastCmd = -1000;
  int lastMrs = -1000, prevRefPost = -1, measStart = 0, refCount = 0, u1Ref = 0;
  int initSeen = 0, acceptCyc = -1000, accesses = 0, reqNum = 0;
  bit haveExp = 0, justAccepted = 1, earlyReady = 0, prevCke = 0, firstAfterMrs = 0;
  logic        expWr;
  logic [19:0] expAddr;

  task automatic newStimulus(input int c);
    int r;
    if (c > RUN - 60) begin reqValid = 1'b0; return; end
    r = int'($urandom % 10);
    case (reqNum)
      0: begin reqValid = 1; reqWrite = 1; reqAddr = 20'h00000; end
      1: begin reqValid = 1; reqWrite = 0; reqAddr = 20'hfffff; end
      2: begin reqValid = 1; reqWrite = 0; reqAddr = 20'h80000; end
      3: begin reqValid = 1; reqWrite = 1; reqAddr = 20'h7ff01; end
      default: begin
        reqValid = (r < 8);
        reqWrite = 1'($urandom);
        reqAddr  = 20'($urandom);
      end
    endcase
    if (reqValid) reqNum++;
  endtask

  task automatic monitor(input int c);
    logic [3:0] cmd;
    bit isCmd, expRv;
    cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
    isCmd = (cmd != C_NOP) && (cmd != C_DES);
    if (c == 1) begin
      chk(sdCke == 1'b1, "R2 cke high after reset", sdCke, 1);
      chk(cmd == C_NOP, "R1 nop after reset", cmd, C_NOP);
    end
    if (isCmd) begin
      chk(prevCke, "R2 cke before command", prevCke, 1);
      chk(cmd inside {C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD}, "R3 legal code", cmd, C_NOP);
    end
    if (initSeen < 4 && reqReady) earlyReady = 1;
    if (isCmd && initSeen < 4) begin
      case (initSeen)
        0: begin
          chk(cmd == C_PRE && sdAddr[10], "R2 first is precharge-all", {cmd, sdAddr[10]}, {C_PRE, 1'b1});
          chk(c >= T_INIT, "R2 init wait", c, T_INIT);
        end
        1: chk(cmd == C_REF && c - lastCmd >= T_RP, "R2 refresh one", c - lastCmd, T_RP);
        2: chk(cmd == C_REF && c - lastCmd >= T_RFC, "R2 refresh two", c - lastCmd, T_RFC);
        default: begin
          chk(cmd == C_MRS && c - lastCmd >= T_RFC, "R2 mode load", cmd, C_MRS);
          chk(sdAddr == 11'(CAS_LAT << 4), "R2 mode word", sdAddr, CAS_LAT << 4);
          chk(!earlyReady, "R2 ready held low", earlyReady, 0);
          measStart = c; lastMrs = c; firstAfterMrs = 1;
        end
      endcase
      initSeen++;
    end else if (isCmd) begin
      if (firstAfterMrs) begin
        chk(c - lastMrs >= T_MRD, "R2 mode recovery", c - lastMrs, T_MRD);
        firstAfterMrs = 0;
      end
      case (cmd)
        C_ACT: begin
          chk(haveExp && c == acceptCyc + 1, "R10 activate one cycle after accept", c, acceptCyc + 1);
          chk(sdBa == expAddr[19], "R4 activate bank", sdBa, expAddr[19]);
          chk(sdAddr == expAddr[18:8], "R4 activate row", sdAddr, expAddr[18:8]);
          chk(c - lastAct >= T_RC, "R6 activate spacing", c - lastAct, T_RC);
          chk(c - lastRw >= T_RP, "R6 precharge recovery", c - lastRw, T_RP);
          chk(c - lastRef >= T_RFC, "R7 refresh recovery", c - lastRef, T_RFC);
          lastAct = c;
        end
        C_RD, C_WR: begin
          chk(cmd == (expWr ? C_WR : C_RD), "R3 direction", cmd, expWr ? C_WR : C_RD);
          chk(c - lastAct == T_RCD, "R5 activate to column", c - lastAct, T_RCD);
          chk(sdBa == expAddr[19] && sdAddr == colWord(expAddr), "R4 column address",
              {sdBa, sdAddr}, {expAddr[19], colWord(expAddr)});
          haveExp = 0; lastRw = c; accesses++;
          if (cmd == C_RD) lastRd = c;
        end
        C_REF: begin
          chk(c - lastRw >= T_RP, "R6 column to refresh", c - lastRw, T_RP);
          chk(c - lastRef >= T_RFC, "R7 refresh spacing", c - lastRef, T_RFC);
          if (prevRefPost >= 0)
            chk(c - prevRefPost <= GAP_FULL + SLACK, "R9 refresh not starved", c - prevRefPost, GAP_FULL + SLACK);
          prevRefPost = c; lastRef = c; refCount++;
        end
        default: chk(0, "R3 no precharge or mode load after start-up", cmd, C_NOP);
      endcase
    end
    if (isCmd) lastCmd = c;
    if (wrDataEn || cmd == C_WR)
      chk(wrDataEn == (cmd == C_WR), "R11 write strobe", wrDataEn, cmd == C_WR);
    expRv = (c == lastRd + CAS_LAT);
    if (rdDataValid || expRv)
      chk(rdDataValid == expRv, "R11 read valid latency", rdDataValid, expRv);
    if (reqReady)
      chk(!haveExp, "R10 single access in flight", reqReady, 0);
    if ({cs1, ras1, cas1, we1} == C_REF && measStart > 0 && c > measStart) u1Ref++;
    prevCke = sdCke;
  endtask

  task automatic drive(input int c);
    if (justAccepted) begin
      newStimulus(c);
      justAccepted = 0;
    end else if (!reqValid) begin
      newStimulus(c);
    end
    if (reqValid && reqReady) begin
      haveExp = 1; acceptCyc = c; expWr = reqWrite; expAddr = reqAddr;
      justAccepted = 1;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    repeat (4) begin
      @(negedge clk);
      chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_DES, "R1 deselect in reset",
          {sdCsN, sdRasN, sdCasN, sdWeN}, C_DES);
      chk(!sdCke && !reqReady, "R1 cke and ready low in reset", {sdCke, reqReady}, 0);
    end
    rstN = 1'b1;
    for (int c = 1; c <= RUN; c++) begin
      @(negedge clk);
      monitor(c);
      drive(c);
    end
    chk(initSeen == 4, "R2 start-up completed", initSeen, 4);
    chk(accesses > 100, "R10 accesses served", accesses, 100);
    begin
      int e;
      e = refExpect(RUN - measStart, GAP_FULL);
      chk(refCount >= e - 1 && refCount <= e + 1, "R8 refresh count full window", refCount, e);
      e = refExpect(RUN - measStart, GAP_HALF);
      chk(u1Ref >= e - 1 && u1Ref <= e + 1, "R8 refresh count half window", u1Ref, e);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WD * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule